// File: doc/BRIEF.md
# Reservation Monitor for Linked Load / Conditional Store

This block sits beside a core's data port and keeps track of addresses that the core has reserved with a load-reserved operation. A later store-conditional to a reserved address is let through to memory only when nothing has written that address in between. Writes counted as interference include a plain store from the same core and a write or invalidation seen on the snoop port from another agent. The outcome is reported in the same cycle as the request: 0 means the store was performed, 1 means it was dropped.

Addresses are compared at granule resolution, meaning the address with its `GRAN_BITS` low bits removed. The table holds `ENTRIES` reservations. When the table is full, a new reservation takes the slot of the least recently reserved one. A reservation also lapses `TIMEOUT` cycles after it was made, so a stale reservation cannot live for ever. The block gives no forward-progress guarantee. A stream of interfering writes can make every conditional store fail.

Top module: `lrsc_monitor`

## Requirements
- R1: Immediately after reset no reservation is held, so a store-conditional fails and produces no memory write.
- R2: A store-conditional (op code 2) to the same granule as an earlier load-reserved (op code 1) with no write in between succeeds. `sc_fail` is 0 and the store appears on the memory write port in the same cycle, with the request's address and data.
- R3: A failing store-conditional raises `sc_done` with `sc_fail` at 1 in the same cycle and produces no memory write.
- R4: A store-conditional uses up the matching reservation whether it succeeds or fails, so a second one to that granule fails.
- R5: A plain store (op code 3) is always forwarded to memory in its own cycle and removes any reservation on its granule.
- R6: A snooped write clears a reservation on the same granule (address shifted right by `GRAN_BITS`, default 2). A snooped write to another granule leaves the reservation in place.
- R7: When a snooped write and a store-conditional to the same granule arrive in one cycle, the snoop takes effect first and the store-conditional fails. When a snooped write and a load-reserved to the same granule arrive together, the new reservation stands.
- R8: With all `ENTRIES` slots in use, a load-reserved to a new granule replaces the least recently reserved entry. A load-reserved to a granule already held renews that entry and occupies no new slot.
- R9: A store-conditional issued k cycles after its load-reserved succeeds for k up to `TIMEOUT` and fails for k greater than `TIMEOUT`.
- R10: A plain load (op code 0) changes no reservation. A store-conditional to a granule without a reservation fails and leaves the other reservations untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present this cycle |
| req_op | input | 2 | 0 load, 1 load-reserved, 2 store-conditional, 3 store |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Store data |
| snoop_valid | input | 1 | Write or invalidation by another agent this cycle |
| snoop_addr | input | ADDR_W | Snooped address |
| mem_wr_valid | output | 1 | Store forwarded to memory this cycle |
| mem_wr_addr | output | ADDR_W | Forwarded store address |
| mem_wr_data | output | DATA_W | Forwarded store data |
| sc_done | output | 1 | A store-conditional is being decided this cycle |
| sc_fail | output | 1 | Result code: 0 success, 1 failure |

## Verification
A store-conditional can collide with a snooped write to its own granule, because both ports are sampled in the same cycle. The bench provokes this by issuing the store-conditional with the snoop port driven to an address inside the reserved granule. It expects a failure code and a silent memory port in that same cycle. The reverse pairing is also tested: a load-reserved together with a same-granule snoop. For that case the bench judges the result by a following store-conditional, which must succeed.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_LR    = 2'd1,
    OP_SC    = 2'd2,
    OP_STORE = 2'd3
  } op_e;

  // Granule number of a byte address (up to 64 address bits).
  function automatic logic [63:0] granule_of(input logic [63:0] addr, input int shift);
    return addr >> shift;
  endfunction

  // True when an entry of the given age must lapse at the next edge.
  function automatic logic age_lapses(input logic [31:0] age, input int limit);
    return age == 32'(limit - 1);
  endfunction

endpackage

// File: rtl/lrsc_slot.sv
module lrsc_slot
  import lrsc_pkg::*;
#(
  parameter int TAG_W   = 30,
  parameter int TIMEOUT = 64,
  localparam int AGE_W  = $clog2(TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_set,
  input  logic [TAG_W-1:0] i_tag,
  input  logic             i_kill,
  output logic             o_valid,
  output logic [TAG_W-1:0] o_tag,
  output logic [AGE_W-1:0] o_age,
  output logic             o_lapse
);

  logic             valid_q;
  logic [TAG_W-1:0] tag_q;
  logic [AGE_W-1:0] age_q;

  assign o_lapse = valid_q && age_lapses(32'(age_q), TIMEOUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      age_q   <= '0;
    end else if (i_set) begin
      valid_q <= 1'b1;
      tag_q   <= i_tag;
      age_q   <= '0;
    end else if (i_kill || o_lapse) begin
      valid_q <= 1'b0;
      age_q   <= '0;
    end else if (valid_q) begin
      age_q   <= age_q + AGE_W'(1);
    end
  end

  assign o_valid = valid_q;
  assign o_tag   = tag_q;
  assign o_age   = age_q;

endmodule

// File: rtl/lrsc_victim.sv
module lrsc_victim #(
  parameter int ENTRIES = 4,
  parameter int AGE_W   = 7,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            i_valid,
  input  logic [ENTRIES-1:0][AGE_W-1:0] i_age,
  output logic [ENTRIES-1:0]            o_pick
);

  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] old_idx;
  logic [AGE_W-1:0] old_age;
  logic [IDX_W-1:0] pick_idx;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!i_valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    old_idx = '0;
    old_age = i_age[0];
    for (int i = 1; i < ENTRIES; i++) begin
      if (i_age[i] > old_age) begin
        old_age = i_age[i];
        old_idx = IDX_W'(i);
      end
    end
  end

  assign pick_idx = free_any ? free_idx : old_idx;

  always_comb begin
    o_pick = '0;
    o_pick[pick_idx] = 1'b1;
  end

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int ENTRIES   = 4,
  parameter int GRAN_BITS = 2,
  parameter int TIMEOUT   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              sc_done,
  output logic              sc_fail
);

  localparam int TAG_W = ADDR_W - GRAN_BITS;
  localparam int AGE_W = $clog2(TIMEOUT + 1);

  logic [TAG_W-1:0] req_tag, snp_tag;
  logic is_lr, is_sc, is_st;

  logic [ENTRIES-1:0]            slot_valid;
  logic [ENTRIES-1:0][TAG_W-1:0] slot_tag;
  logic [ENTRIES-1:0][AGE_W-1:0] slot_age;
  logic [ENTRIES-1:0]            slot_lapse;
  logic [ENTRIES-1:0]            hit_req, hit_snp;
  logic [ENTRIES-1:0]            slot_set, slot_kill;
  logic [ENTRIES-1:0]            victim;

  // Named internal events
  logic ev_lr_renew;
  logic ev_sc_pass;

  assign req_tag = TAG_W'(granule_of(64'(req_addr), GRAN_BITS));
  assign snp_tag = TAG_W'(granule_of(64'(snoop_addr), GRAN_BITS));

  assign is_lr = req_valid && (req_op == OP_LR);
  assign is_sc = req_valid && (req_op == OP_SC);
  assign is_st = req_valid && (req_op == OP_STORE);

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_slot
      assign hit_req[g]   = slot_valid[g] && (slot_tag[g] == req_tag);
      assign hit_snp[g]   = snoop_valid && slot_valid[g] && (slot_tag[g] == snp_tag);
      assign slot_kill[g] = hit_snp[g] || ((is_sc || is_st) && hit_req[g]);
      assign slot_set[g]  = is_lr && (ev_lr_renew ? hit_req[g] : victim[g]);

      lrsc_slot #(
        .TAG_W  (TAG_W),
        .TIMEOUT(TIMEOUT)
      ) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .i_set  (slot_set[g]),
        .i_tag  (req_tag),
        .i_kill (slot_kill[g]),
        .o_valid(slot_valid[g]),
        .o_tag  (slot_tag[g]),
        .o_age  (slot_age[g]),
        .o_lapse(slot_lapse[g])
      );
    end
  endgenerate

  lrsc_victim #(
    .ENTRIES(ENTRIES),
    .AGE_W  (AGE_W)
  ) u_victim (
    .i_valid(slot_valid),
    .i_age  (slot_age),
    .o_pick (victim)
  );

  assign ev_lr_renew = |hit_req;
  assign ev_sc_pass  = is_sc && |(hit_req & ~hit_snp);

  assign mem_wr_valid = is_st || ev_sc_pass;
  assign mem_wr_addr  = req_addr;
  assign mem_wr_data  = req_wdata;
  assign sc_done      = is_sc;
  assign sc_fail      = is_sc && !ev_sc_pass;

endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk
  import lrsc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ENTRIES   = 4,
  parameter int GRAN_BITS = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         req_op,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               snoop_valid,
  input logic [ADDR_W-1:0]  snoop_addr,
  input logic               mem_wr_valid,
  input logic [ADDR_W-1:0]  mem_wr_addr,
  input logic               sc_done,
  input logic               sc_fail,
  input logic [ENTRIES-1:0] slot_valid,
  input logic [ENTRIES-1:0] hit_req
);

  logic same_gran_snoop;
  assign same_gran_snoop = snoop_valid &&
    (granule_of(64'(snoop_addr), GRAN_BITS) == granule_of(64'(req_addr), GRAN_BITS));

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> slot_valid == '0);

  a_r2_pass_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_done && !sc_fail) |-> (mem_wr_valid && mem_wr_addr == req_addr));

  a_r3_fail_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_done && sc_fail) |-> !mem_wr_valid);

  a_r4_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && sc_done && $past(sc_done) &&
     granule_of(64'(req_addr), GRAN_BITS) == granule_of(64'($past(req_addr)), GRAN_BITS))
    |-> sc_fail);

  a_r5_store_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd3) |-> mem_wr_valid);

  a_r7_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_done && same_gran_snoop) |-> sc_fail);

  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_req));

endmodule

bind lrsc_monitor lrsc_monitor_chk #(
  .ADDR_W   (ADDR_W),
  .ENTRIES  (ENTRIES),
  .GRAN_BITS(GRAN_BITS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_addr    (req_addr),
  .snoop_valid (snoop_valid),
  .snoop_addr  (snoop_addr),
  .mem_wr_valid(mem_wr_valid),
  .mem_wr_addr (mem_wr_addr),
  .sc_done     (sc_done),
  .sc_fail     (sc_fail),
  .slot_valid  (slot_valid),
  .hit_req     (hit_req)
);

// File: tb/lrsc_monitor_tb.sv
module lrsc_monitor_tb;

  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int NE  = 4;
  localparam int TMO = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          mem_wr_valid;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic          sc_done, sc_fail;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lrsc_monitor #(
    .ADDR_W(AW), .DATA_W(DW), .ENTRIES(NE), .GRAN_BITS(2), .TIMEOUT(TMO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .sc_done(sc_done), .sc_fail(sc_fail)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus at the falling edge and sample the
  // combinational outputs before the next rising edge.
  logic s_wv, s_done, s_fail;
  logic [AW-1:0] s_wa;
  logic [DW-1:0] s_wd;

  task automatic step(input logic v, input logic [1:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic sv, input logic [AW-1:0] sa);
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = a; req_wdata = d;
    snoop_valid = sv; snoop_addr = sa;
    #1;
    s_wv = mem_wr_valid; s_wa = mem_wr_addr; s_wd = mem_wr_data;
    s_done = sc_done; s_fail = sc_fail;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, '0, 1'b0, '0);
  endtask

  task automatic lr(input logic [AW-1:0] a);
    step(1'b1, 2'd1, a, '0, 1'b0, '0);
  endtask

  task automatic sc_expect(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic exp_fail, input logic sv = 1'b0,
                           input logic [AW-1:0] sa = '0);
    step(1'b1, 2'd2, a, d, sv, sa);
    check({tag, " sc_done"}, 64'(s_done), 64'(1));
    check({tag, " sc_fail"}, 64'(s_fail), 64'(exp_fail));
    check({tag, " mem_wr_valid"}, 64'(s_wv), 64'(!exp_fail));
    if (!exp_fail) begin
      check({tag, " mem_wr_addr"}, 64'(s_wa), 64'(a));
      check({tag, " mem_wr_data"}, 64'(s_wd), 64'(d));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; snoop_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    idle(1);
    check("R1 idle mem_wr_valid", 64'(s_wv), 64'(0));
    check("R1 idle sc_done", 64'(s_done), 64'(0));
    sc_expect("R1 sc after reset", 32'h100, 32'hAAAA, 1'b1);
  endtask

  task automatic t_basic();
    do_reset();
    lr(32'h200);
    sc_expect("R2 lr/sc pass", 32'h202, 32'h1234, 1'b0);
    sc_expect("R4 R3 second sc fails", 32'h200, 32'h5678, 1'b1);
  endtask

  task automatic t_store();
    do_reset();
    lr(32'h300);
    step(1'b1, 2'd3, 32'h301, 32'hBEEF, 1'b0, '0);
    check("R5 store forwarded", 64'(s_wv), 64'(1));
    check("R5 store addr", 64'(s_wa), 64'(32'h301));
    check("R5 store data", 64'(s_wd), 64'(32'hBEEF));
    check("R5 store not sc", 64'(s_done), 64'(0));
    sc_expect("R5 sc after local store", 32'h300, 32'h1, 1'b1);
  endtask

  task automatic t_snoop();
    do_reset();
    lr(32'h400);
    step(1'b0, 2'd0, '0, '0, 1'b1, 32'h403);
    sc_expect("R6 sc after same-granule snoop", 32'h400, 32'h2, 1'b1);
    lr(32'h500);
    step(1'b0, 2'd0, '0, '0, 1'b1, 32'h504);
    sc_expect("R6 sc after other-granule snoop", 32'h500, 32'h3, 1'b0);
  endtask

  task automatic t_collide();
    do_reset();
    lr(32'h600);
    sc_expect("R7 sc with same-cycle snoop", 32'h600, 32'h4, 1'b1, 1'b1, 32'h602);
    step(1'b1, 2'd1, 32'h700, '0, 1'b1, 32'h701);
    sc_expect("R7 lr with same-cycle snoop holds", 32'h700, 32'h5, 1'b0);
  endtask

  task automatic t_evict();
    do_reset();
    for (int i = 0; i < NE; i++) lr(AW'(32'h1000 + 16 * i));
    lr(32'h2000);
    sc_expect("R8 oldest evicted", 32'h1000, 32'h6, 1'b1);
    for (int i = 1; i < NE; i++) sc_expect("R8 younger kept", AW'(32'h1000 + 16 * i), 32'h7, 1'b0);
    sc_expect("R8 newest kept", 32'h2000, 32'h8, 1'b0);
    do_reset();
    for (int i = 0; i < NE; i++) lr(AW'(32'h1000 + 16 * i));
    lr(32'h1000);
    lr(32'h2000);
    sc_expect("R8 renewed entry kept", 32'h1000, 32'h9, 1'b0);
    sc_expect("R8 second-oldest evicted", 32'h1010, 32'hA, 1'b1);
  endtask

  task automatic t_timeout();
    do_reset();
    lr(32'h800);
    idle(TMO - 1);
    sc_expect("R9 sc at timeout limit", 32'h800, 32'hB, 1'b0);
    lr(32'h800);
    idle(TMO);
    sc_expect("R9 sc past timeout", 32'h800, 32'hC, 1'b1);
  endtask

  task automatic t_other();
    do_reset();
    lr(32'h900);
    step(1'b1, 2'd0, 32'h900, '0, 1'b0, '0);
    check("R10 load no write", 64'(s_wv), 64'(0));
    check("R10 load no sc", 64'(s_done), 64'(0));
    sc_expect("R10 sc to unreserved", 32'hA00, 32'hD, 1'b1);
    sc_expect("R10 reservation survives", 32'h900, 32'hE, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_store();
    t_snoop();
    t_collide();
    t_evict();
    t_timeout();
    t_other();
    idle(2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule